// File: doc/BRIEF.md
# Serial Flash Erase Sequencer

This block turns one erase request into the run of erase commands that a page-organised serial flash needs. A request names a first page and a number of pages. At each step the sequencer picks either an eight-page block erase or a single-page erase. It sends the command as one chip-select frame to a byte-level SPI engine. It then reads the device status in short frames until the ready flag comes back. After that it moves on by the span it just erased.

The block drives chip select and one byte at a time toward the SPI engine, and takes back one received byte per transfer. Bit shifting and bus sharing belong to the engine and are not part of this block. The page geometry comes from parameters: the device size in pages, the left shift that turns a page index into a device address, the block span and the idle gap before each status read. A request that does not fit in the device is refused with a one-cycle pulse.

Top module: `flash_erase_seq`

## Requirements
- R1: A request whose start page plus page count is larger than NUM_PAGES is refused. `reject` pulses for exactly the cycle after the request is sampled, `busy` stays low and no frame is started. A request that ends exactly at NUM_PAGES is accepted.
- R2: `busy` rises in the cycle after an accepted request and stays high through the cycle that carries `done`. A `reqValid` seen while `busy` is high has no effect on the command stream or on the number of `done` pulses.
- R3: A step uses block erase only when the current page index is a multiple of BLOCK_PAGES (8) and at least BLOCK_PAGES pages remain. Every other step uses page erase.
- R4: The first byte of an erase frame is 0x50 for block erase and 0x81 for page erase. The first byte of every frame is 0x50, 0x81 or 0xD7.
- R5: An erase frame has exactly four bytes, in this order: opcode, device address bits 23:16, device address bits 15:8, 0x00. The device address is the page index shifted left by PAGE_SHIFT. The byte offered to the engine holds steady until the engine completes it.
- R6: After each erase frame the block sends status frames of exactly two bytes, 0xD7 then 0x00. It reads bit 7 of the byte received with the second one, where 1 means ready. It repeats the status frame until that bit is 1, whatever the other status bits are.
- R7: Chip select is low between any two frames. Before every status frame, chip select stays low for exactly POLL_GAP cycles. The byte request is never raised outside a frame.
- R8: A block erase moves the page index on by 8 and the remaining count down by 8. A page erase moves them by 1. `done` pulses for one cycle once the remaining count is zero. A request with a count of zero gives `done` with no frame at all.
- R9: Out of reset, `busy`, `done`, `reject`, `spiCs` and `spiByteReq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Erase request strobe, sampled while idle |
| reqStartPage | input | $clog2(NUM_PAGES) | First page to erase |
| reqPageCount | input | $clog2(NUM_PAGES+1) | Number of pages to erase |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle pulse when the request completes |
| reject | output | 1 | One-cycle pulse when a request does not fit the device |
| spiCs | output | 1 | Chip select to the byte engine, high while a frame is open |
| spiByteReq | output | 1 | Byte transfer request, held until completion |
| spiTxByte | output | 8 | Byte to shift out |
| spiByteDone | input | 1 | One-cycle pulse from the engine when a byte has been shifted |
| spiRxByte | input | 8 | Byte received during the transfer that just completed |

## Verification
The bench sweeps every start page of a 48-page device with a 2048-byte page shift, so device addresses reach above 64 KiB. Each start is paired with counts of 0, 1, 2, 7, 8, 9, 16, 17 and the count that ends exactly at the device edge. This separates the aligned and unaligned cases, the cases with just enough and one too few pages left for a block, and the runs that mix block and page steps. The modelled flash answers block erases with two not-ready polls and page erases with one. Its not-ready status has every bit except bit 7 set, so the number of polls shows whether only the ready bit is read. One count past the device edge is tried at each start to check refusal. A second request sent in the middle of a run shows whether a request during `busy` is really ignored.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_GAP,
    ST_POLL,
    ST_STEP,
    ST_NEXT
  } seqState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic loadReq;
    logic advance;
    logic byteClr;
    logic byteInc;
    logic gapLoad;
    logic selPoll;
  } seqStrobe_t;

  localparam logic [7:0] OP_BLOCK_ERASE = 8'h50;
  localparam logic [7:0] OP_PAGE_ERASE  = 8'h81;
  localparam logic [7:0] OP_STATUS_RD   = 8'hD7;
  localparam logic [7:0] FILL_BYTE      = 8'h00;
  localparam logic [7:0] READY_MASK     = 8'h80;
  localparam int         CMD_BYTES      = 4;
  localparam int         POLL_BYTES     = 2;

endpackage

// File: rtl/flash_erase_cmdfmt.sv
module flash_erase_cmdfmt
  import flash_erase_pkg::*;
(
  input  logic        isBlock,
  input  logic        selPoll,
  input  logic [1:0]  byteIdx,
  input  logic [15:0] addrHi,   // device address bits 23:8
  output logic [7:0]  txByte
);

  always_comb begin
    if (selPoll) begin
      txByte = (byteIdx == 2'd0) ? OP_STATUS_RD : FILL_BYTE;
    end else begin
      unique case (byteIdx)
        2'd0:    txByte = isBlock ? OP_BLOCK_ERASE : OP_PAGE_ERASE;
        2'd1:    txByte = addrHi[15:8];
        2'd2:    txByte = addrHi[7:0];
        default: txByte = FILL_BYTE;
      endcase
    end
  end

endmodule

// File: rtl/flash_erase_dp.sv
module flash_erase_dp
  import flash_erase_pkg::*;
#(
  parameter int NUM_PAGES   = 2048,
  parameter int PAGE_SHIFT  = 9,
  parameter int BLOCK_PAGES = 8,
  parameter int POLL_GAP    = 16,
  localparam int PG_W  = $clog2(NUM_PAGES),
  localparam int CNT_W = $clog2(NUM_PAGES + 1)
)(
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic [PG_W-1:0]  reqStartPage,
  input  logic [CNT_W-1:0] reqPageCount,
  input  logic [7:0]       spiRxByte,
  output logic             reqFits,
  output logic             remZero,
  output logic             gapDone,
  output logic             lastByte,
  output logic             statusReady,
  output logic [7:0]       spiTxByte
);

  localparam int ADDR_W = 24;
  localparam int SUM_W  = CNT_W + 1;
  localparam int GAP_W  = $clog2(POLL_GAP + 1);

  logic [CNT_W-1:0] curPage, remPages, stepSize;
  logic [1:0]       byteIdx;
  logic [GAP_W-1:0] gapCnt;
  logic             isBlock;
  logic [15:0]      addrHi;

  assign reqFits = (SUM_W'(reqStartPage) + SUM_W'(reqPageCount)) <= SUM_W'(NUM_PAGES);

  assign isBlock  = ((curPage & CNT_W'(BLOCK_PAGES - 1)) == '0) &&
                    (remPages >= CNT_W'(BLOCK_PAGES));
  assign stepSize = isBlock ? CNT_W'(BLOCK_PAGES) : CNT_W'(1);
  assign remZero  = (remPages == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curPage  <= '0;
      remPages <= '0;
    end else if (strobe.loadReq) begin
      curPage  <= CNT_W'(reqStartPage);
      remPages <= reqPageCount;
    end else if (strobe.advance) begin
      curPage  <= curPage + stepSize;
      remPages <= remPages - stepSize;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               byteIdx <= '0;
    else if (strobe.byteClr) byteIdx <= '0;
    else if (strobe.byteInc) byteIdx <= byteIdx + 2'd1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)               gapCnt <= '0;
    else if (strobe.gapLoad) gapCnt <= GAP_W'(POLL_GAP - 1);
    else if (gapCnt != '0)   gapCnt <= gapCnt - GAP_W'(1);
  end

  assign gapDone     = (gapCnt == '0);
  assign lastByte    = strobe.selPoll ? (byteIdx == 2'(POLL_BYTES - 1))
                                      : (byteIdx == 2'(CMD_BYTES - 1));
  assign statusReady = |(spiRxByte & READY_MASK);
  assign addrHi      = 16'((ADDR_W'(curPage) << PAGE_SHIFT) >> 8);

  flash_erase_cmdfmt fmt_i (
    .isBlock (isBlock),
    .selPoll (strobe.selPoll),
    .byteIdx (byteIdx),
    .addrHi  (addrHi),
    .txByte  (spiTxByte)
  );

endmodule

// File: rtl/flash_erase_ctrl.sv
module flash_erase_ctrl
  import flash_erase_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqFits,
  input  logic       remZero,
  input  logic       gapDone,
  input  logic       lastByte,
  input  logic       statusReady,
  input  logic       spiByteDone,
  output seqStrobe_t strobe,
  output logic       busy,
  output logic       done,
  output logic       reject,
  output logic       spiCs,
  output logic       spiByteReq
);

  seqState_t state, stateNxt;
  logic      rejectQ;

  always_comb begin
    stateNxt       = state;
    strobe         = '0;
    strobe.selPoll = (state == ST_POLL);
    unique case (state)
      ST_IDLE: begin
        if (reqValid && reqFits) begin
          strobe.loadReq = 1'b1;
          strobe.byteClr = 1'b1;
          stateNxt       = ST_NEXT;
        end
      end
      ST_CMD: begin
        if (spiByteDone) begin
          if (lastByte) begin
            strobe.byteClr = 1'b1;
            strobe.gapLoad = 1'b1;
            stateNxt       = ST_GAP;
          end else begin
            strobe.byteInc = 1'b1;
          end
        end
      end
      ST_GAP: begin
        if (gapDone) stateNxt = ST_POLL;
      end
      ST_POLL: begin
        if (spiByteDone) begin
          if (lastByte) begin
            strobe.byteClr = 1'b1;
            if (statusReady) begin
              stateNxt = ST_STEP;
            end else begin
              strobe.gapLoad = 1'b1;
              stateNxt       = ST_GAP;
            end
          end else begin
            strobe.byteInc = 1'b1;
          end
        end
      end
      ST_STEP: begin
        strobe.advance = 1'b1;
        stateNxt       = ST_NEXT;
      end
      ST_NEXT: begin
        stateNxt = remZero ? ST_IDLE : ST_CMD;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      rejectQ <= 1'b0;
    end else begin
      state   <= stateNxt;
      rejectQ <= (state == ST_IDLE) && reqValid && !reqFits;
    end
  end

  assign busy       = (state != ST_IDLE);
  assign done       = (state == ST_NEXT) && remZero;
  assign reject     = rejectQ;
  assign spiCs      = (state == ST_CMD) || (state == ST_POLL);
  assign spiByteReq = spiCs;

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import flash_erase_pkg::*;
#(
  parameter int NUM_PAGES   = 2048,
  parameter int PAGE_SHIFT  = 9,
  parameter int BLOCK_PAGES = 8,
  parameter int POLL_GAP    = 16,
  localparam int PG_W  = $clog2(NUM_PAGES),
  localparam int CNT_W = $clog2(NUM_PAGES + 1)
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [PG_W-1:0]  reqStartPage,
  input  logic [CNT_W-1:0] reqPageCount,
  output logic             busy,
  output logic             done,
  output logic             reject,
  output logic             spiCs,
  output logic             spiByteReq,
  output logic [7:0]       spiTxByte,
  input  logic             spiByteDone,
  input  logic [7:0]       spiRxByte
);

  seqStrobe_t strobe;
  logic reqFits, remZero, gapDone, lastByte, statusReady;

  flash_erase_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqFits     (reqFits),
    .remZero     (remZero),
    .gapDone     (gapDone),
    .lastByte    (lastByte),
    .statusReady (statusReady),
    .spiByteDone (spiByteDone),
    .strobe      (strobe),
    .busy        (busy),
    .done        (done),
    .reject      (reject),
    .spiCs       (spiCs),
    .spiByteReq  (spiByteReq)
  );

  flash_erase_dp #(
    .NUM_PAGES   (NUM_PAGES),
    .PAGE_SHIFT  (PAGE_SHIFT),
    .BLOCK_PAGES (BLOCK_PAGES),
    .POLL_GAP    (POLL_GAP)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .reqStartPage (reqStartPage),
    .reqPageCount (reqPageCount),
    .spiRxByte    (spiRxByte),
    .reqFits      (reqFits),
    .remZero      (remZero),
    .gapDone      (gapDone),
    .lastByte     (lastByte),
    .statusReady  (statusReady),
    .spiTxByte    (spiTxByte)
  );

endmodule

// File: rtl/flash_erase_chk.sv
module flash_erase_chk (
  input logic       clk,
  input logic       rstN,
  input logic       busy,
  input logic       done,
  input logic       reject,
  input logic       spiCs,
  input logic       spiByteReq,
  input logic [7:0] spiTxByte,
  input logic       spiByteDone
);

  // R1: a refusal never coincides with an active run or open frame
  a_r1_reject_idle: assert property (@(posedge clk) disable iff (!rstN)
    reject |-> (!busy && !spiCs));

  // R2: completion is reported inside the busy window
  a_r2_done_in_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

  // R8: done is a single-cycle pulse and ends the run
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

  // R4: every frame opens with a known opcode
  a_r4_first_byte: assert property (@(posedge clk) disable iff (!rstN)
    $rose(spiCs) |-> (spiTxByte == 8'h50 || spiTxByte == 8'h81 || spiTxByte == 8'hD7));

  // R5: the offered byte holds until the engine completes it
  a_r5_tx_hold: assert property (@(posedge clk) disable iff (!rstN)
    (spiByteReq && !spiByteDone) |=> (!spiByteReq || $stable(spiTxByte)));

  // R7: no byte request outside a frame
  a_r7_req_framed: assert property (@(posedge clk) disable iff (!rstN)
    spiByteReq |-> spiCs);

endmodule

bind flash_erase_seq flash_erase_chk chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .busy        (busy),
  .done        (done),
  .reject      (reject),
  .spiCs       (spiCs),
  .spiByteReq  (spiByteReq),
  .spiTxByte   (spiTxByte),
  .spiByteDone (spiByteDone)
);

// File: tb/flash_erase_seq_tb_top.sv
`timescale 1ns/1ps
module flash_erase_seq_tb_top;

  localparam int NP    = 48;
  localparam int PS    = 11;
  localparam int BP    = 8;
  localparam int GAP   = 3;
  localparam int PG_W  = $clog2(NP);
  localparam int CNT_W = $clog2(NP + 1);

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             reqValid = 1'b0;
  logic [PG_W-1:0]  reqStartPage = '0;
  logic [CNT_W-1:0] reqPageCount = '0;
  logic             busy, done, reject, spiCs, spiByteReq;
  logic [7:0]       spiTxByte;
  logic             spiByteDone = 1'b0;
  logic [7:0]       spiRxByte = 8'hFF;

  always #4 clk = ~clk;

  flash_erase_seq #(
    .NUM_PAGES(NP), .PAGE_SHIFT(PS), .BLOCK_PAGES(BP), .POLL_GAP(GAP)
  ) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .reqStartPage(reqStartPage), .reqPageCount(reqPageCount),
    .busy(busy), .done(done), .reject(reject),
    .spiCs(spiCs), .spiByteReq(spiByteReq), .spiTxByte(spiTxByte),
    .spiByteDone(spiByteDone), .spiRxByte(spiRxByte)
  );

  int nTests = 0;
  int nFail  = 0;
  bit finished = 0;

  // expected erase stream for the running request
  logic [31:0] expFrame [0:63];
  int expN = 0, expPos = 0, expPolls = 0;
  int pollSeen = 0, doneSeen = 0, frameTotal = 0;

  // bus monitor / device model state
  logic [7:0] fBuf [0:7];
  int  fIdx = 0, lowRun = 0, lastLow = 0, busyLeft = 0;
  bit  prevCs = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic processFrame();
    frameTotal++;
    if (fIdx == 2 && fBuf[0] == 8'hD7) begin
      pollSeen++;
      check("R6 status frame second byte", {24'd0, fBuf[1]}, 32'h0);
      check("R7 chip select gap before status read", lastLow, GAP);
    end else if (fIdx == 4) begin
      check("R3 R4 R5 erase frame", {fBuf[0], fBuf[1], fBuf[2], fBuf[3]},
            (expPos < expN) ? expFrame[expPos] : 32'hDEADBEEF);
      expPos++;
      busyLeft = (fBuf[0] == 8'h50) ? 2 : 1;
    end else begin
      check("R5 R6 frame length", fIdx, 4);
    end
  endtask

  always @(negedge clk) begin
    if (!rstN) begin
      fIdx = 0; lowRun = 0; prevCs = 0; spiByteDone = 1'b0;
    end else begin
      if (prevCs && !spiCs) begin
        processFrame();
        fIdx = 0;
      end
      if (spiCs && !prevCs) lastLow = lowRun;
      if (spiCs) lowRun = 0; else lowRun++;
      prevCs = spiCs;
      if (done) doneSeen++;
      if (spiByteDone) begin
        spiByteDone = 1'b0;
      end else if (spiByteReq) begin
        if (fIdx < 8) fBuf[fIdx] = spiTxByte;
        if (fIdx == 1 && fBuf[0] == 8'hD7) begin
          if (busyLeft > 0) begin
            spiRxByte = 8'h7F;
            busyLeft--;
          end else begin
            spiRxByte = 8'h80;
          end
        end else begin
          spiRxByte = 8'hFF;
        end
        fIdx++;
        spiByteDone = 1'b1;
      end
    end
  end

  task automatic buildExpected(input int start, input int count);
    int p = start, r = count;
    expN = 0; expPos = 0; expPolls = 0;
    while (r > 0) begin
      bit blk = ((p % BP) == 0) && (r >= BP);
      int a = p << PS;
      expFrame[expN] = {blk ? 8'h50 : 8'h81, 8'(a >> 16), 8'(a >> 8), 8'h00};
      expN++;
      expPolls += blk ? 3 : 2;
      if (blk) begin p += BP; r -= BP; end
      else begin p += 1; r -= 1; end
    end
  endtask

  task automatic runReq(input int start, input int count, input bit intrude);
    int t = 0;
    int f0;
    buildExpected(start, count);
    pollSeen = 0; doneSeen = 0; f0 = frameTotal;
    @(negedge clk);
    reqValid = 1'b1; reqStartPage = PG_W'(start); reqPageCount = CNT_W'(count);
    @(negedge clk);
    reqValid = 1'b0;
    check("R2 busy after accept", busy, 1);
    if (intrude) begin
      repeat (5) @(negedge clk);
      reqValid = 1'b1; reqStartPage = PG_W'(1); reqPageCount = CNT_W'(2);
      @(negedge clk);
      reqValid = 1'b0;
    end
    while (!done && t < 20000) begin
      @(negedge clk);
      t++;
    end
    repeat (3) @(negedge clk);
    check("R8 erase frames issued", expPos, expN);
    check("R6 status polls", pollSeen, expPolls);
    check("R8 single done", doneSeen, 1);
    check("R2 busy low after done", busy, 0);
    if (count == 0) check("R8 zero count no traffic", frameTotal - f0, 0);
  endtask

  task automatic rejectReq(input int start, input int count);
    int f0 = frameTotal;
    @(negedge clk);
    reqValid = 1'b1; reqStartPage = PG_W'(start); reqPageCount = CNT_W'(count);
    @(negedge clk);
    reqValid = 1'b0;
    check("R1 reject pulse", {reject, busy}, 2'b10);
    @(negedge clk);
    check("R1 reject single cycle", {reject, busy, spiCs}, 3'b000);
    repeat (2) @(negedge clk);
    check("R1 no traffic on reject", frameTotal - f0, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nTests++; nFail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    int counts [0:7] = '{0, 1, 2, 7, 8, 9, 16, 17};
    repeat (3) @(negedge clk);
    check("R9 reset state", {busy, done, reject, spiCs, spiByteReq}, 5'b0);
    rstN = 1'b1;
    @(negedge clk);
    check("R9 idle after reset", {busy, done, reject, spiCs, spiByteReq}, 5'b0);

    for (int s = 0; s < NP; s++) begin
      for (int k = 0; k < 8; k++) begin
        if (s + counts[k] <= NP) runReq(s, counts[k], 1'b0);
      end
      runReq(s, NP - s, 1'b0);
      rejectReq(s, NP - s + 1);
    end
    rejectReq(NP - 1, (1 << CNT_W) - 1);
    runReq(0, NP, 1'b1);
    runReq(3, 20, 1'b1);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule